// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit linear address into a physical address. It reads page table entries itself over a single 32-bit memory read/write port. A request carries the linear address, a write flag and the current privilege level. The walker fetches the directory entry from the table named by the directory frame input. When that entry does not map a large page, it goes on to fetch the table entry. It then checks presence and access rights, writes back the accessed and dirty flags when they change, and returns either a physical address or a fault.

Pages are 4 KB. When the large-page enable input is high, a directory entry with its size flag set maps a 4 MB page directly. When paging is disabled, the linear address is returned unchanged after one cycle and memory is not touched. The last faulting linear address is held on a dedicated output.

The controller is one state machine with seven states:
- IDLE waits for a request.
- READ_PDE fetches the directory entry.
- UPDATE_PDE writes that entry back with its flags set.
- READ_PTE fetches the table entry.
- UPDATE_PTE writes that entry back with its flags set.
- DONE presents a translation for one cycle.
- FAULT presents a fault for one cycle.

Transitions:
- IDLE goes to READ_PDE, or to DONE when paging is off.
- READ_PDE goes to FAULT, UPDATE_PDE, READ_PTE or DONE.
- UPDATE_PDE goes to READ_PTE, or to DONE for a large page.
- READ_PTE goes to FAULT, UPDATE_PTE or DONE.
- UPDATE_PTE goes to DONE.
- DONE and FAULT both return to IDLE.

Top module: `pt_walker`

## Requirements
- R1: With `paging_en` low, an accepted request gives `resp_valid` with `resp_phys` equal to the linear address in the next cycle, no fault, and no memory request.
- R2: For a 4 KB page, bits [31:22] index the directory and bits [21:12] index the table. The directory entry is read at `{dir_frame, lin[31:22], 2'b00}`. The table entry is read at `{pde[31:12], lin[21:12], 2'b00}`. The result is `{pte[31:12], lin[11:0]}`.
- R3: A directory entry with bit 7 set maps a 4 MB page only while `large_en` is high. In that case no table entry is read and the result is `{pde[31:22], lin[21:0]}`. While `large_en` is low, bit 7 is ignored and a 4 KB walk is made.
- R4: An entry with bit 0 (present) clear ends the walk. The walker raises `resp_fault` with code 1, stores the linear address on `fault_addr`, and writes nothing back for that entry.
- R5: Bit 5 (accessed) is set in every entry used to reach the page and is never cleared. A write-back happens only when the entry value actually changes, so each walk uses exactly one read per level plus one write per changed entry.
- R6: Bit 6 (dirty) is set only in the final-level entry, and only on a write. It is never cleared.
- R7: Bit 2 (user) must be 1 in every entry used when `req_cpl` is 3. Otherwise the walker faults with code 2. Levels 0 to 2 ignore bit 2.
- R8: Bit 1 (writable) must be 1 in every entry used for a write. Otherwise the walker faults with code 3. Priority is not-present, then privilege, then write-protect. `fault_wr` reports the request's write flag during a fault.
- R9: `req_ready` is high only in IDLE, and a request is accepted when `req_valid` is seen there. `resp_valid` is a single-cycle pulse. After reset the block is idle with `fault_addr` zero. A memory request holds its address and write flag until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable |
| large_en | input | 1 | 4 MB page enable |
| dir_frame | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| req_cpl | input | 2 | Current privilege level |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Result is a fault |
| resp_phys | output | 32 | Physical address |
| fault_code | output | 2 | 0 none, 1 not present, 2 privilege, 3 write-protect |
| fault_wr | output | 1 | Write flag of the faulting request |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry write-back value |
| mem_rdata | input | 32 | Entry read data, valid with ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
A wrong state or a wrong transition shows first at the memory port. A missing or extra read or write-back changes the count of memory cycles and the stored entries. These are compared after every walk, within the same request. A wrong captured entry or fault decision shows as a wrong `resp_phys` or `fault_code` on the very pulse that ends the walk. A state that fails to return to IDLE shows as `req_ready` staying low and is caught by the next request or by the run time limit.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int TBL_W     = 10;
    localparam int DIR_W     = VA_W - OFF_W - TBL_W;
    localparam int BIG_OFF_W = OFF_W + TBL_W;
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int BIG_W     = VA_W - BIG_OFF_W;
    localparam int FLG_W     = 3;

    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_PDE,
        S_UPDATE_PDE,
        S_READ_PTE,
        S_UPDATE_PTE,
        S_DONE,
        S_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FC_NONE        = 2'd0,
        FC_NOT_PRESENT = 2'd1,
        FC_PRIV        = 2'd2,
        FC_WPROT       = 2'd3
    } fault_code_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_walk_pkg::*;
(
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [VA_W-1:0]    lin,
    input  logic [FRAME_W-1:0] pde_frame,
    input  logic [FRAME_W-1:0] pte_frame,
    input  logic               big,
    input  logic               bypass,
    output logic [VA_W-1:0]    pde_addr,
    output logic [VA_W-1:0]    pte_addr,
    output logic [VA_W-1:0]    phys
);
    always_comb begin
        pde_addr = {dir_frame, lin[VA_W-1 -: DIR_W], 2'b00};
        pte_addr = {pde_frame, lin[BIG_OFF_W-1 -: TBL_W], 2'b00};
        if (bypass)
            phys = lin;
        else if (big)
            phys = {pde_frame[FRAME_W-1 -: BIG_W], lin[BIG_OFF_W-1:0]};
        else
            phys = {pte_frame, lin[OFF_W-1:0]};
    end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walk_pkg::*;
(
    input  logic [FLG_W-1:0] upper_flags,
    input  logic [FLG_W-1:0] lower_flags,
    input  logic [1:0]       cpl,
    input  logic             wr,
    output fault_code_t      code
);
    always_comb begin
        code = FC_NONE;
        if (!(upper_flags[B_P] && lower_flags[B_P]))
            code = FC_NOT_PRESENT;
        else if ((cpl == 2'd3) && !(upper_flags[B_US] && lower_flags[B_US]))
            code = FC_PRIV;
        else if (wr && !(upper_flags[B_RW] && lower_flags[B_RW]))
            code = FC_WPROT;
    end

    // R7: a privilege fault is only ever reported for the user level
    always_comb begin
        if (code == FC_PRIV) begin
            assert_priv_user_R7: assert (cpl == 2'd3);
        end
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paging_en,
    input  logic               large_en,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_lin,
    input  logic               req_write,
    input  logic [1:0]         req_cpl,
    output logic               req_ready,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [1:0]         fault_code,
    output logic               fault_wr,
    output logic [VA_W-1:0]    fault_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    input  logic [VA_W-1:0]    mem_rdata,
    input  logic               mem_ack,
    input  logic [VA_W-1:0]    pde_addr,
    input  logic [VA_W-1:0]    pte_addr,
    output logic [VA_W-1:0]    lin_o,
    output logic [FRAME_W-1:0] pde_frame_o,
    output logic [FRAME_W-1:0] pte_frame_o,
    output logic               big_o,
    output logic               bypass_o,
    output logic [FLG_W-1:0]   chk_upper,
    output logic [FLG_W-1:0]   chk_lower,
    output logic [1:0]         chk_cpl,
    output logic               chk_wr,
    input  fault_code_t        chk_code
);
    walk_state_t       state, nxt;
    logic [VA_W-1:0]   lin_q, pde_q, pte_q, fault_addr_q;
    logic              wr_q, big_q, bypass_q, large_q;
    logic [1:0]        cpl_q;
    fault_code_t       code_q;
    logic [VA_W-1:0]   pde_upd, pte_upd, rd_big_upd, rd_pte_upd, ent_old;
    logic              rd_big;

    function automatic logic [VA_W-1:0] mark(input logic [VA_W-1:0] ent, input logic dirty);
        logic [VA_W-1:0] r;
        r = ent;
        r[B_A] = 1'b1;
        if (dirty) r[B_D] = 1'b1;
        return r;
    endfunction

    always_comb begin
        rd_big     = mem_rdata[B_PS] && large_q;
        rd_big_upd = mark(mem_rdata, wr_q);
        rd_pte_upd = mark(mem_rdata, wr_q);
        pde_upd    = mark(pde_q, big_q && wr_q);
        pte_upd    = mark(pte_q, wr_q);
        ent_old    = (state == S_UPDATE_PDE) ? pde_q : pte_q;
    end

    // permission checker operands
    always_comb begin
        chk_cpl = cpl_q;
        chk_wr  = wr_q;
        if (state == S_READ_PTE) begin
            chk_upper = pde_q[FLG_W-1:0];
            chk_lower = mem_rdata[FLG_W-1:0];
        end else begin
            chk_upper = mem_rdata[FLG_W-1:0];
            chk_lower = {FLG_W{1'b1}};
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) nxt = paging_en ? S_READ_PDE : S_DONE;
            end
            S_READ_PDE: begin
                if (mem_ack) begin
                    if (!mem_rdata[B_P])
                        nxt = S_FAULT;
                    else if (rd_big) begin
                        if (chk_code != FC_NONE)        nxt = S_FAULT;
                        else if (rd_big_upd != mem_rdata) nxt = S_UPDATE_PDE;
                        else                              nxt = S_DONE;
                    end else begin
                        nxt = mem_rdata[B_A] ? S_READ_PTE : S_UPDATE_PDE;
                    end
                end
            end
            S_UPDATE_PDE: begin
                if (mem_ack) nxt = big_q ? S_DONE : S_READ_PTE;
            end
            S_READ_PTE: begin
                if (mem_ack) begin
                    if (chk_code != FC_NONE)          nxt = S_FAULT;
                    else if (rd_pte_upd != mem_rdata) nxt = S_UPDATE_PTE;
                    else                              nxt = S_DONE;
                end
            end
            S_UPDATE_PTE: begin
                if (mem_ack) nxt = S_DONE;
            end
            S_DONE:  nxt = S_IDLE;
            S_FAULT: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q        <= '0;
            pde_q        <= '0;
            pte_q        <= '0;
            wr_q         <= 1'b0;
            cpl_q        <= 2'd0;
            big_q        <= 1'b0;
            bypass_q     <= 1'b0;
            large_q      <= 1'b0;
            code_q       <= FC_NONE;
            fault_addr_q <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                lin_q    <= req_lin;
                wr_q     <= req_write;
                cpl_q    <= req_cpl;
                bypass_q <= !paging_en;
                large_q  <= large_en;
                big_q    <= 1'b0;
                code_q   <= FC_NONE;
            end
            if (state == S_READ_PDE && mem_ack) begin
                pde_q  <= mem_rdata;
                big_q  <= rd_big;
                if (!mem_rdata[B_P]) code_q <= FC_NOT_PRESENT;
                else if (rd_big)     code_q <= chk_code;
            end
            if (state == S_READ_PTE && mem_ack) begin
                pte_q  <= mem_rdata;
                code_q <= chk_code;
            end
            if (nxt == S_FAULT && state != S_FAULT)
                fault_addr_q <= lin_q;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == S_IDLE);
        resp_valid = (state == S_DONE) || (state == S_FAULT);
        resp_fault = (state == S_FAULT);
        fault_code = (state == S_FAULT) ? code_q : FC_NONE;
        fault_wr   = (state == S_FAULT) && wr_q;
        fault_addr = fault_addr_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = pde_addr;
        mem_wdata  = '0;
        unique case (state)
            S_READ_PDE:   mem_req = 1'b1;
            S_UPDATE_PDE: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = pde_upd; end
            S_READ_PTE:   begin mem_req = 1'b1; mem_addr = pte_addr; end
            S_UPDATE_PTE: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = pte_addr; mem_wdata = pte_upd; end
            default: ;
        endcase
        lin_o       = lin_q;
        pde_frame_o = pde_q[VA_W-1:OFF_W];
        pte_frame_o = pte_q[VA_W-1:OFF_W];
        big_o       = big_q;
        bypass_o    = bypass_q;
    end

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid && !paging_en) |=> (resp_valid && !resp_fault && !mem_req));

    assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (fault_addr == lin_q));

    assert_wb_changes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != ent_old));

    assert_dirty_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wdata[B_D] && !ent_old[B_D]) |-> wr_q);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paging_en,
    input  logic               large_en,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_lin,
    input  logic               req_write,
    input  logic [1:0]         req_cpl,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [VA_W-1:0]    resp_phys,
    output logic [1:0]         fault_code,
    output logic               fault_wr,
    output logic [VA_W-1:0]    fault_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    input  logic [VA_W-1:0]    mem_rdata,
    input  logic               mem_ack
);
    logic [VA_W-1:0]    pde_addr, pte_addr, lin_w;
    logic [FRAME_W-1:0] pde_frame, pte_frame;
    logic               big_w, bypass_w, chk_wr;
    logic [FLG_W-1:0]   chk_upper, chk_lower;
    logic [1:0]         chk_cpl;
    fault_code_t        chk_code;

    pt_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .paging_en  (paging_en),
        .large_en   (large_en),
        .req_valid  (req_valid),
        .req_lin    (req_lin),
        .req_write  (req_write),
        .req_cpl    (req_cpl),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .fault_code (fault_code),
        .fault_wr   (fault_wr),
        .fault_addr (fault_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .pde_addr   (pde_addr),
        .pte_addr   (pte_addr),
        .lin_o      (lin_w),
        .pde_frame_o(pde_frame),
        .pte_frame_o(pte_frame),
        .big_o      (big_w),
        .bypass_o   (bypass_w),
        .chk_upper  (chk_upper),
        .chk_lower  (chk_lower),
        .chk_cpl    (chk_cpl),
        .chk_wr     (chk_wr),
        .chk_code   (chk_code)
    );

    pt_addr_gen u_addr (
        .dir_frame (dir_frame),
        .lin       (lin_w),
        .pde_frame (pde_frame),
        .pte_frame (pte_frame),
        .big       (big_w),
        .bypass    (bypass_w),
        .pde_addr  (pde_addr),
        .pte_addr  (pte_addr),
        .phys      (resp_phys)
    );

    pt_perm_check u_perm (
        .upper_flags (chk_upper),
        .lower_flags (chk_lower),
        .cpl         (chk_cpl),
        .wr          (chk_wr),
        .code        (chk_code)
    );
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b1, large_en = 1'b1;
    logic [19:0] dir_frame = 20'h0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_lin = '0;
    logic [1:0]  req_cpl = 2'd0;
    logic        req_ready, resp_valid, resp_fault, fault_wr;
    logic [31:0] resp_phys, fault_addr;
    logic [1:0]  fault_code;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int errors = 0;
    int checks = 0;
    int mem_cycles = 0;
    logic [31:0] mem [0:4095];

    always #2.5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .large_en(large_en),
        .dir_frame(dir_frame), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_cpl(req_cpl),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_phys(resp_phys),
        .fault_code(fault_code), .fault_wr(fault_wr), .fault_addr(fault_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end else begin
            mem_ack <= 1'b0;
        end
        if (rst_n && mem_req) mem_cycles <= mem_cycles + 1;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_perm(input logic [31:0] u, input logic [31:0] l,
                                            input logic [1:0] cpl, input logic wr);
        if (!(u[0] && l[0]))                 return 2'd1;
        if (cpl == 2'd3 && !(u[2] && l[2]))  return 2'd2;
        if (wr && !(u[1] && l[1]))           return 2'd3;
        return 2'd0;
    endfunction

    task automatic do_req(input logic [31:0] lin, input logic wr, input logic [1:0] cpl);
        logic [31:0] pa, ta, pde, pte, npde, npte, ephys;
        logic [1:0]  ecode;
        logic        use_pte, touch_pde;
        int          etrans, start_cycles;
        string       tag;
        pa = {dir_frame, lin[31:22], 2'b00};
        pde = mem[pa[13:2]];
        npde = pde; npte = '0; ta = '0; pte = '0;
        use_pte = 1'b0; touch_pde = 1'b0; ecode = 2'd0; ephys = lin; etrans = 0;
        tag = "R2";
        if (!paging_en) begin
            tag = "R1";
        end else if (!pde[0]) begin
            ecode = 2'd1; etrans = 1; touch_pde = 1'b1; tag = "R4";
        end else if (pde[7] && large_en) begin
            tag = "R3"; etrans = 1; touch_pde = 1'b1;
            ecode = exp_perm(pde, 32'hFFFF_FFFF, cpl, wr);
            if (ecode == 2'd0) begin
                npde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (npde != pde) etrans++;
                ephys = {pde[31:22], lin[21:0]};
            end
        end else begin
            touch_pde = 1'b1; use_pte = 1'b1;
            npde = pde | 32'h20;
            etrans = (npde != pde) ? 3 : 2;
            ta = {pde[31:12], lin[21:12], 2'b00};
            pte = mem[ta[13:2]];
            npte = pte;
            ecode = exp_perm(pde, pte, cpl, wr);
            if (ecode == 2'd0) begin
                npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (npte != pte) etrans++;
                ephys = {pte[31:12], lin[11:0]};
            end
        end
        if (ecode == 2'd1) tag = "R4";
        if (ecode == 2'd2) tag = "R7";
        if (ecode == 2'd3) tag = "R8";

        @(negedge clk);
        start_cycles = mem_cycles;
        req_lin = lin; req_write = wr; req_cpl = cpl; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "ready low while busy", {31'b0, req_ready}, 32'd0);
        while (!resp_valid) @(negedge clk);
        check(tag, "fault flag", {31'b0, resp_fault}, {31'b0, (ecode != 2'd0)});
        check(tag, "fault code", {30'b0, fault_code}, {30'b0, ecode});
        if (ecode != 2'd0) begin
            check("R4", "fault address", fault_addr, lin);
            check("R8", "fault write flag", {31'b0, fault_wr}, {31'b0, wr});
        end else begin
            check(tag, "physical address", resp_phys, ephys);
        end
        check(paging_en ? "R5" : "R1", "memory cycles", mem_cycles - start_cycles, 2 * etrans);
        if (touch_pde) check("R5", "directory entry after walk", mem[pa[13:2]], npde);
        if (use_pte)   check("R6", "table entry after walk", mem[ta[13:2]], npte);
        @(negedge clk);
        check("R9", "single response pulse", {31'b0, resp_valid}, 32'd0);
    endtask

    function automatic logic [31:0] mk(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // directory (frame 0)
        mem[1] = 32'h0000_1007;   // 4 KB, user, writable, table at frame 1
        mem[2] = 32'h0000_2005;   // 4 KB, user, read-only, table at frame 2
        mem[3] = 32'h0040_3087;   // large page, user, writable (4 KB: table aliases frame 3)
        mem[4] = 32'h00C0_3083;   // large page, supervisor
        mem[5] = 32'h0000_1003;   // 4 KB, supervisor, writable, table at frame 1
        mem[1024 + 7]  = 32'hABCD_E007;
        mem[2048 + 9]  = 32'h1234_5007;
        mem[1024 + 20] = 32'h5555_5006;  // not present
        mem[3072 + 1]  = 32'h7777_7067;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset ready", {31'b0, req_ready}, 32'd1);
        check("R9", "reset resp_valid", {31'b0, resp_valid}, 32'd0);
        check("R9", "reset mem_req", {31'b0, mem_req}, 32'd0);
        check("R9", "reset fault_addr", fault_addr, 32'd0);

        paging_en = 1'b0;
        do_req(32'hDEAD_BEEF, 1'b1, 2'd3);          // R1 pass-through
        paging_en = 1'b1;
        do_req(mk(0, 3, 12'h123), 1'b0, 2'd0);      // R4 directory not present
        do_req(mk(1, 7, 12'h406), 1'b0, 2'd3);      // R2 read, accessed set (R5)
        do_req(mk(1, 7, 12'h010), 1'b1, 2'd3);      // R6 dirty set on write
        do_req(mk(1, 7, 12'h010), 1'b1, 2'd3);      // R5 no write-back needed
        do_req(mk(2, 9, 12'hFFF), 1'b1, 2'd3);      // R8 read-only directory
        do_req(mk(2, 9, 12'h001), 1'b0, 2'd3);      // user read ok
        do_req(mk(5, 7, 12'h002), 1'b0, 2'd3);      // R7 supervisor directory
        do_req(mk(5, 7, 12'h003), 1'b1, 2'd0);      // supervisor write ok
        do_req(mk(3, 1, 12'h555), 1'b1, 2'd3);      // R3 large page
        do_req(mk(4, 2, 12'h666), 1'b0, 2'd3);      // R7 large supervisor
        do_req(mk(1, 20, 12'h0), 1'b0, 2'd0);       // R4 table not present
        large_en = 1'b0;
        do_req(mk(3, 1, 12'h444), 1'b0, 2'd3);      // R3 size flag ignored
        large_en = 1'b1;

        for (int n = 0; n < 400; n++) begin
            int d, t;
            logic [31:0] r;
            d = int'($urandom_range(0, 5));
            t = int'($urandom_range(0, 1023));
            r = $urandom();
            if (d != 0) begin
                if ($urandom_range(0, 1) == 1) mem[d] = mem[d] & ~32'h60;
                case (d)
                    1, 5: mem[1024 + t] = r;
                    2:    mem[2048 + t] = r;
                    default: mem[3072 + t] = r;
                endcase
            end
            paging_en = ($urandom_range(0, 9) != 0);
            large_en  = $urandom_range(0, 1) == 1;
            do_req(mk(d, t, int'($urandom_range(0, 4095))), $urandom_range(0, 1) == 1,
                   2'($urandom_range(0, 3)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule